// File: doc/BRIEF.md
# Multi-CPU Interrupt Router

This block collects level-sensitive interrupt requests and steers each one to the processor cores allowed to service it. Shared peripheral sources pass through three gates: a global enable, a routing bitmap that names the cores a source may reach, and a per-core mask. Three source numbers are private to each core: two doorbell summaries and a local timer line. Each core drives its own level for these, and only that core's mask gates them.

Software changes enable and mask state by writing a source number to a set or a clear register, so no read-modify-write is needed. The mask registers act on the core that issues the access, which the bus gives as a core index. Each core reads an acknowledge register that returns the lowest-numbered source currently eligible for it, or the value 1023 when none is. A per-core interrupt output is high whenever that core has an eligible source.

Top module: `irq_router`

## Requirements
- R1: After reset every source is disabled, every per-core mask bit is set and every routing bitmap is zero. The acknowledge register reads 1023 for both cores, `cpu_irq` is 0 and routing registers read 0, whatever the source levels are.
- R2: A read of offset 0x000 returns the number of implemented source IDs in bits [11:2] and zero in all other bits (64 for 16 sources).
- R3: Writing a source ID in `bus_wdata[9:0]` to offset 0x030 enables that source, and writing it to 0x034 disables it. An ID of NUM_SRC or above changes nothing and does not alias onto a lower ID.
- R4: Writing a source ID to 0x048 masks it, and writing it to 0x04C unmasks it, only for the core named on `bus_cpu`. The other cores' masks are left unchanged.
- R5: The routing register of source ID n sits at 0x100 + 4·n. Its bits [NUM_CPUS-1:0] are read/write, bit c routes the source to core c, and all higher bits read 0.
- R6: A shared source is eligible for core c exactly while its input is high, it is enabled, its routing bit c is set and it is unmasked for core c. It stops being eligible as soon as its input falls.
- R7: A read of 0x044 returns in bits [9:0] the lowest eligible ID for the reading core, or 1023 when none is eligible. The read has no side effect.
- R8: `cpu_irq[c]` is high exactly when core c has at least one eligible source.
- R9: IDs 0 (`ipi_sum`), 1 (`msi_sum`) and 5 (`tmr_lvl`) take their level from the core's own input bit and are gated only by that core's mask bit. Their `src_lvl` bits, enable bits and routing bits have no effect.
- R10: A shared source whose routing bitmap excludes a core is never reported to that core, whether through its acknowledge register or through its `cpu_irq` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | Index of the core issuing the access |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read strobe |
| src_lvl | input | NUM_SRC | Level of each shared source, indexed by ID |
| ipi_sum | input | NUM_CPUS | Per-core inter-processor doorbell summary (ID 0) |
| msi_sum | input | NUM_CPUS | Per-core message-signalled doorbell summary (ID 1) |
| tmr_lvl | input | NUM_CPUS | Per-core private timer level (ID 5) |
| cpu_irq | output | NUM_CPUS | Interrupt request to each core |

## Verification
The hardest case to reach is a source whose ID is private while every shared-path gate for that ID is open: its `src_lvl` bit is high, it is enabled and it is routed to both cores. Only a block that wrongly mixes the two paths will then report it. The stimulus enables and routes ID 5 deliberately, then toggles the per-core timer level and the per-core mask to show that only those two decide. A second hard case is an out-of-range ID written to the enable register. Its low bits match a routed, unmasked source, so aliasing would show up as a spurious acknowledge.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NONE_ID = 10'd1023;

  localparam int OFS_CTRL    = 'h000;
  localparam int OFS_EN_SET  = 'h030;
  localparam int OFS_EN_CLR  = 'h034;
  localparam int OFS_ACK     = 'h044;
  localparam int OFS_MSK_SET = 'h048;
  localparam int OFS_MSK_CLR = 'h04C;
  localparam int OFS_ROUTE   = 'h100;

  localparam int ID_IPI = 0;
  localparam int ID_MSI = 1;
  localparam int ID_TMR = 5;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_EN_SET,
    ACC_EN_CLR,
    ACC_MSK_SET,
    ACC_MSK_CLR,
    ACC_ROUTE
  } acc_kind_e;

  function automatic logic is_private(input int id);
    return (id == ID_IPI) || (id == ID_MSI) || (id == ID_TMR);
  endfunction

endpackage

// File: rtl/irq_router_state.sv
module irq_router_state
  import irq_router_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NUM_SRC  = 16,
  localparam int CPU_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int SRC_IDX_W = $clog2(NUM_SRC)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  acc_kind_e                          acc_kind,
  input  logic [SRC_IDX_W-1:0]               acc_id,
  input  logic [CPU_W-1:0]                   acc_cpu,
  input  logic [NUM_CPUS-1:0]                acc_route,
  output logic [NUM_SRC-1:0]                 en_q,
  output logic [NUM_CPUS-1:0][NUM_SRC-1:0]   mask_q,
  output logic [NUM_SRC-1:0][NUM_CPUS-1:0]   route_q
);

  logic [NUM_SRC-1:0]               en_d;
  logic [NUM_CPUS-1:0][NUM_SRC-1:0] mask_d;
  logic [NUM_SRC-1:0][NUM_CPUS-1:0] route_d;
  logic en_ce, mask_ce, route_ce;

  assign en_ce    = (acc_kind == ACC_EN_SET)  || (acc_kind == ACC_EN_CLR);
  assign mask_ce  = (acc_kind == ACC_MSK_SET) || (acc_kind == ACC_MSK_CLR);
  assign route_ce = (acc_kind == ACC_ROUTE);

  always_comb begin
    en_d    = en_q;
    mask_d  = mask_q;
    route_d = route_q;
    case (acc_kind)
      ACC_EN_SET:  en_d[acc_id] = 1'b1;
      ACC_EN_CLR:  en_d[acc_id] = 1'b0;
      ACC_MSK_SET: mask_d[acc_cpu][acc_id] = 1'b1;
      ACC_MSK_CLR: mask_d[acc_cpu][acc_id] = 1'b0;
      ACC_ROUTE:   route_d[acc_id] = acc_route;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mask_q  <= '1;
      route_q <= '0;
    end else begin
      if (en_ce)    en_q    <= en_d;
      if (mask_ce)  mask_q  <= mask_d;
      if (route_ce) route_q <= route_d;
    end
  end

  // R3: a clear-enable access leaves the addressed source disabled
  assert_en_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == ACC_EN_CLR) |=> !en_q[$past(acc_id)]);

  // R3: a set-enable access leaves the addressed source enabled
  assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == ACC_EN_SET) |=> en_q[$past(acc_id)]);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_mask_chk
    // R4: a mask access by one core leaves every other core's mask alone
    assert_mask_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_ce && (acc_cpu != CPU_W'(c))) |=> $stable(mask_q[c]));
  end

endmodule

// File: rtl/irq_router_pick.sv
module irq_router_pick
  import irq_router_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NUM_SRC  = 16,
  localparam int SRC_IDX_W = $clog2(NUM_SRC)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_SRC-1:0]                 src_lvl,
  input  logic [NUM_CPUS-1:0]                ipi_sum,
  input  logic [NUM_CPUS-1:0]                msi_sum,
  input  logic [NUM_CPUS-1:0]                tmr_lvl,
  input  logic [NUM_SRC-1:0]                 en_q,
  input  logic [NUM_CPUS-1:0][NUM_SRC-1:0]   mask_q,
  input  logic [NUM_SRC-1:0][NUM_CPUS-1:0]   route_q,
  output logic [NUM_CPUS-1:0][ID_W-1:0]      ack_id,
  output logic [NUM_CPUS-1:0]                irq
);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] below;
    logic [ID_W-1:0]    sel;

    always_comb begin
      for (int i = 0; i < NUM_SRC; i++) begin
        elig[i] = src_lvl[i] & en_q[i] & route_q[i][c] & ~mask_q[c][i];
      end
      elig[ID_IPI] = ipi_sum[c] & ~mask_q[c][ID_IPI];
      elig[ID_MSI] = msi_sum[c] & ~mask_q[c][ID_MSI];
      elig[ID_TMR] = tmr_lvl[c] & ~mask_q[c][ID_TMR];
    end

    always_comb begin
      sel = NONE_ID;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
        if (elig[i]) sel = ID_W'(i);
      end
    end

    assign ack_id[c] = sel;
    assign irq[c]    = |elig;
    assign below     = ~({NUM_SRC{1'b1}} << sel);

    // R10: a shared source is only ever reported to a core it is routed to
    assert_route_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[c] && !is_private(32'(sel))) |-> route_q[sel[SRC_IDX_W-1:0]][c]);

    // R7: the reported ID is eligible and no lower ID is
    assert_lowest_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> (elig[sel[SRC_IDX_W-1:0]] && ($countones(elig & below) == 0)));
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NUM_SRC  = 16,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  localparam int CPU_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int SRC_IDX_W = $clog2(NUM_SRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [CPU_W-1:0]    bus_cpu,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_SRC-1:0]  src_lvl,
  input  logic [NUM_CPUS-1:0] ipi_sum,
  input  logic [NUM_CPUS-1:0] msi_sum,
  input  logic [NUM_CPUS-1:0] tmr_lvl,
  output logic [NUM_CPUS-1:0] cpu_irq
);

  localparam int ROUTE_END = OFS_ROUTE + 4 * NUM_SRC;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // access decode
  logic                  wr, rd;
  logic [ID_W-1:0]       wr_id;
  logic                  id_ok;
  logic                  in_route;
  logic [ADDR_W-1:0]     route_off;
  logic [SRC_IDX_W-1:0]  route_idx;
  acc_kind_e             acc_kind;
  logic [SRC_IDX_W-1:0]  acc_id;

  assign wr        = bus_en & bus_we;
  assign rd        = bus_en & ~bus_we;
  assign wr_id     = bus_wdata[ID_W-1:0];
  assign id_ok     = (wr_id < ID_W'(NUM_SRC));
  assign in_route  = (bus_addr >= ADDR_W'(OFS_ROUTE)) && (bus_addr < ADDR_W'(ROUTE_END))
                     && (bus_addr[1:0] == 2'b00);
  assign route_off = bus_addr - ADDR_W'(OFS_ROUTE);
  assign route_idx = route_off[SRC_IDX_W+1:2];

  always_comb begin
    acc_kind = ACC_NONE;
    acc_id   = wr_id[SRC_IDX_W-1:0];
    if (wr) begin
      if (in_route) begin
        acc_kind = ACC_ROUTE;
        acc_id   = route_idx;
      end else if (id_ok) begin
        if      (bus_addr == ADDR_W'(OFS_EN_SET))  acc_kind = ACC_EN_SET;
        else if (bus_addr == ADDR_W'(OFS_EN_CLR))  acc_kind = ACC_EN_CLR;
        else if (bus_addr == ADDR_W'(OFS_MSK_SET)) acc_kind = ACC_MSK_SET;
        else if (bus_addr == ADDR_W'(OFS_MSK_CLR)) acc_kind = ACC_MSK_CLR;
      end
    end
  end

  logic [NUM_SRC-1:0]               en_q;
  logic [NUM_CPUS-1:0][NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0][NUM_CPUS-1:0] route_q;
  logic [NUM_CPUS-1:0][ID_W-1:0]    ack_id;

  irq_router_state #(.NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC)) u_state (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .acc_kind  (acc_kind),
    .acc_id    (acc_id),
    .acc_cpu   (bus_cpu),
    .acc_route (bus_wdata[NUM_CPUS-1:0]),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .route_q   (route_q)
  );

  irq_router_pick #(.NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC)) u_pick (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .src_lvl (src_lvl),
    .ipi_sum (ipi_sum),
    .msi_sum (msi_sum),
    .tmr_lvl (tmr_lvl),
    .en_q    (en_q),
    .mask_q  (mask_q),
    .route_q (route_q),
    .ack_id  (ack_id),
    .irq     (cpu_irq)
  );

  // read data: next-state and register
  logic [DATA_W-1:0] rdata_d, rdata_q;

  always_comb begin
    rdata_d = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL))     rdata_d[11:2]         = 10'(NUM_SRC);
    else if (bus_addr == ADDR_W'(OFS_ACK)) rdata_d[ID_W-1:0]     = ack_id[bus_cpu];
    else if (in_route)                     rdata_d[NUM_CPUS-1:0] = route_q[route_idx];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (rd)     rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[DATA_W-1:ID_W], route_off[ADDR_W-1:SRC_IDX_W+2],
                         route_off[1:0]};

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_irq_chk
    // R8: request line agrees with the acknowledge value
    assert_irq_matches_ack_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
      cpu_irq[c] == (ack_id[c] != NONE_ID));
  end

endmodule

// File: tb/irq_router_test.sv
module irq_router_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [0:0]  bus_cpu;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] src_lvl;
  logic [1:0]  ipi_sum, msi_sum, tmr_lvl;
  logic [1:0]  cpu_irq;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  irq_router uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_cpu(bus_cpu),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_lvl(src_lvl), .ipi_sum(ipi_sum), .msi_sum(msi_sum), .tmr_lvl(tmr_lvl),
    .cpu_irq(cpu_irq)
  );

  typedef struct packed {
    logic        rd;
    logic        cpu;
    logic [11:0] addr;
    logic [31:0] data;
    logic [15:0] src;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 28;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 12'h000, 32'd64,   16'h0000, 4'd2},  // R2 control
    '{1'b1, 1'b0, 12'h044, 32'd1023, 16'hFFFF, 4'd1},  // R1 all disabled
    '{1'b1, 1'b1, 12'h044, 32'd1023, 16'hFFFF, 4'd1},  // R1
    '{1'b1, 1'b0, 12'h10C, 32'd0,    16'h0000, 4'd1},  // R1 route zero
    '{1'b0, 1'b0, 12'h030, 32'd3,    16'h0000, 4'd3},  // R3 enable 3
    '{1'b0, 1'b0, 12'h10C, 32'd1,    16'h0000, 4'd5},  // R5 route 3 to cpu0
    '{1'b1, 1'b0, 12'h044, 32'd1023, 16'hFFFF, 4'd6},  // R6 still masked
    '{1'b0, 1'b0, 12'h04C, 32'd3,    16'h0000, 4'd4},  // R4 unmask 3 cpu0
    '{1'b1, 1'b0, 12'h044, 32'd3,    16'hFFFF, 4'd6},  // R6
    '{1'b1, 1'b1, 12'h044, 32'd1023, 16'hFFFF, 4'd10}, // R10
    '{1'b0, 1'b1, 12'h04C, 32'd3,    16'h0000, 4'd4},  // R4 unmask 3 cpu1
    '{1'b1, 1'b1, 12'h044, 32'd1023, 16'hFFFF, 4'd10}, // R10 not routed
    '{1'b1, 1'b0, 12'h044, 32'd1023, 16'h0000, 4'd6},  // R6 level low
    '{1'b0, 1'b0, 12'h030, 32'd9,    16'h0000, 4'd3},  // R3 enable 9
    '{1'b0, 1'b0, 12'h124, 32'd3,    16'h0000, 4'd5},  // R5 route 9 to both
    '{1'b0, 1'b0, 12'h04C, 32'd9,    16'h0000, 4'd4},  // R4
    '{1'b0, 1'b1, 12'h04C, 32'd9,    16'h0000, 4'd4},  // R4
    '{1'b1, 1'b1, 12'h044, 32'd9,    16'hFFFF, 4'd7},  // R7
    '{1'b1, 1'b0, 12'h044, 32'd3,    16'hFFFF, 4'd7},  // R7 lowest wins
    '{1'b1, 1'b0, 12'h044, 32'd9,    16'hFFF7, 4'd6},  // R6 src3 low
    '{1'b0, 1'b0, 12'h034, 32'd3,    16'h0000, 4'd3},  // R3 disable 3
    '{1'b1, 1'b0, 12'h044, 32'd9,    16'hFFFF, 4'd3},  // R3
    '{1'b0, 1'b0, 12'h048, 32'd9,    16'h0000, 4'd4},  // R4 mask 9 cpu0
    '{1'b1, 1'b0, 12'h044, 32'd1023, 16'hFFFF, 4'd4},  // R4
    '{1'b1, 1'b1, 12'h044, 32'd9,    16'hFFFF, 4'd4},  // R4 cpu1 untouched
    '{1'b0, 1'b0, 12'h124, 32'hFFFFFFFF, 16'h0000, 4'd5}, // R5
    '{1'b1, 1'b0, 12'h124, 32'd3,    16'h0000, 4'd5},  // R5 upper bits zero
    '{1'b1, 1'b0, 12'h13C, 32'd0,    16'h0000, 4'd5}   // R5 last entry
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic c, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_cpu = c; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic c, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_cpu = c; bus_addr = a;
    @(posedge clk);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    finish_run();
  end

  initial begin
    logic [31:0] rv, rv2;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_cpu = '0; bus_addr = '0;
    bus_wdata = '0; src_lvl = '0; ipi_sum = '0; msi_sum = '0; tmr_lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: no request after reset even with all inputs high
    src_lvl = 16'hFFFF; ipi_sum = 2'b11; msi_sum = 2'b11; tmr_lvl = 2'b11;
    #2 check("R1", 32'(cpu_irq), 32'd0);
    src_lvl = '0; ipi_sum = '0; msi_sum = '0; tmr_lvl = '0;

    for (int k = 0; k < NVEC; k++) begin
      src_lvl = VECS[k].src;
      if (VECS[k].rd) begin
        bus_read(VECS[k].cpu, VECS[k].addr, rv);
        check($sformatf("R%0d vec%0d", VECS[k].req, k), rv, VECS[k].data);
      end else begin
        bus_write(VECS[k].cpu, VECS[k].addr, VECS[k].data);
      end
    end

    // R8 / R10: request lines with 9 masked on cpu0, 3 disabled
    src_lvl = 16'hFFFF;
    #2 check("R8 R10", 32'(cpu_irq), 32'd2);

    // R3: out-of-range ID 18 must not alias onto ID 2
    bus_write(1'b0, 12'h108, 32'd1);
    bus_write(1'b0, 12'h04C, 32'd2);
    bus_write(1'b0, 12'h030, 32'd18);
    bus_read(1'b0, 12'h044, rv);
    check("R3 out-of-range", rv, 32'd1023);
    bus_write(1'b0, 12'h030, 32'd2);
    bus_read(1'b0, 12'h044, rv);
    check("R3 enable 2", rv, 32'd2);

    // R9: timer ID is private even when enabled and routed on the shared path
    bus_write(1'b0, 12'h030, 32'd5);
    bus_write(1'b0, 12'h114, 32'd3);
    bus_write(1'b0, 12'h034, 32'd2);
    tmr_lvl = 2'b01;
    bus_read(1'b0, 12'h044, rv);
    check("R9 timer masked", rv, 32'd1023);
    bus_write(1'b0, 12'h04C, 32'd5);
    bus_read(1'b0, 12'h044, rv);
    check("R9 timer cpu0", rv, 32'd5);
    bus_read(1'b1, 12'h044, rv);
    check("R9 timer cpu1 masked", rv, 32'd9);
    tmr_lvl = 2'b00;
    bus_read(1'b0, 12'h044, rv);
    check("R9 timer low", rv, 32'd1023);

    // R9: doorbell summaries per core
    bus_write(1'b1, 12'h04C, 32'd0);
    ipi_sum = 2'b10;
    bus_read(1'b1, 12'h044, rv);
    check("R9 ipi cpu1", rv, 32'd0);
    ipi_sum = 2'b01;
    bus_read(1'b1, 12'h044, rv);
    check("R9 ipi other core", rv, 32'd9);
    bus_read(1'b0, 12'h044, rv);
    check("R9 ipi cpu0 masked", rv, 32'd1023);
    ipi_sum = 2'b00;
    bus_write(1'b1, 12'h04C, 32'd1);
    msi_sum = 2'b10;
    bus_read(1'b1, 12'h044, rv);
    check("R9 msi cpu1", rv, 32'd1);

    // R7: acknowledge read has no side effect
    bus_read(1'b1, 12'h044, rv2);
    check("R7 repeat read", rv2, 32'd1);
    check("R8 cpu_irq", 32'(cpu_irq), 32'd2);

    finish_run();
  end

endmodule